// File: doc/BRIEF.md
# Address-Latching Cartridge Mapper

This block sits on the cartridge side of an 8-bit 6502-style console bus. It holds two 8-bit pointer registers that together form a 16-bit byte pointer into an external ROM of up to 128K and an external RAM of up to 64K. Any bus cycle inside the mapper window loads a pointer register from the data bus, whether the CPU reads or writes. A read therefore captures whatever byte appears on the bus, which may come from a mirror of console RAM. Software steps the pointer with read-modify-write instructions aimed at the window, then reaches single bytes of external memory through a second decoded region.

The expanded-memory region selects ROM or RAM by one address bit. One further CPU address bit supplies the seventeenth ROM address bit, so a 128K ROM is reached as two 64K halves. The upper nibble of the high pointer also selects one of sixteen 8K CHR RAM banks. Pointer capture happens on the clock edge that ends a qualified bus cycle. Chip selects follow the address combinationally.

Top module: `addr_latch_mapper`

## Requirements
- R1: While rst_ni is low, and after its release, both pointers read zero; rom_cs_no, ram_cs_no and ram_we_no read 1 while no cycle is active.
- R2: The window is open only when romsel_ni = 1, cpu_addr_i[12] = 1 and m2_i = 1. When any of these is false, neither pointer changes.
- R3: In an open window with cpu_addr_i[4] = 1, lo_ptr_o takes data_i at the clock edge ending the cycle. With bit 4 = 0, lo_ptr_o holds.
- R4: In an open window with cpu_addr_i[5] = 1, hi_ptr_o takes data_i at that edge. With bit 5 = 0, hi_ptr_o holds.
- R5: When bits 4 and 5 are both 1, both pointers take the same data byte at the same edge.
- R6: rw_i has no effect on pointer loading: a read cycle (rw_i = 1) loads exactly as a write cycle does.
- R7: The expanded region is an open window with cpu_addr_i[11] = 1. Inside it, cpu_addr_i[2] = 1 drives ram_cs_no low and cpu_addr_i[2] = 0 drives rom_cs_no low, in the same cycle. Outside it, both selects are 1, and they are never both low.
- R8: rom_addr_o = {cpu_addr_i[0], hi_ptr_o, lo_ptr_o} and ram_addr_o = {hi_ptr_o, lo_ptr_o}. A pointer loaded by a cycle appears in these outputs from the next cycle on.
- R9: chr_bank_o equals hi_ptr_o[7:4].
- R10: ram_we_no is low only when ram_cs_no is low and rw_i = 0. The ROM has no write strobe.
- R11: An expanded-region access whose address also has bit 4 or bit 5 set loads the matching pointer in that same cycle, while the select for that access still uses the old pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock; the rising edge ends a bus cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| romsel_ni | input | 1 | ROM-select strobe, active low; 1 means the lower CPU space |
| m2_i | input | 1 | Bus phase qualifier, 1 during the data phase |
| rw_i | input | 1 | CPU read/write, 1 = read |
| cpu_addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus as seen by the cartridge |
| lo_ptr_o | output | 8 | Low pointer register |
| hi_ptr_o | output | 8 | High pointer register |
| rom_addr_o | output | 17 | External ROM byte address |
| ram_addr_o | output | 16 | External RAM byte address |
| chr_bank_o | output | 4 | CHR RAM 8K bank number |
| rom_cs_no | output | 1 | External ROM select, active low |
| ram_cs_no | output | 1 | External RAM select, active low |
| ram_we_no | output | 1 | External RAM write strobe, active low |

## Verification
Chip selects, the RAM write strobe and ROM address bit 16 are due in the same cycle as the stimulus. The bench samples them one time unit after it drives the inputs, before the capture edge. Pointer loads, the CHR bank and the pointer part of both memory addresses are due one clock edge later. The bench samples those on the falling edge after the capturing rising edge, after it has returned the bus to idle. The test for R11 samples the same cycle twice, so it confirms that the select still shows the old pointer and that the new value appears only afterwards.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ADDR_W       = 16;
  localparam int BIT_LO_LD    = 4;
  localparam int BIT_HI_LD    = 5;
  localparam int BIT_EXT      = 11;
  localparam int BIT_WIN      = 12;
  localparam int BIT_RAM_SEL  = 2;
  localparam int BIT_BANK16   = 0;
  localparam int NUM_PTR      = 2;

  localparam logic [ADDR_W-1:0] DEC_MASK =
    (ADDR_W'(1) << BIT_LO_LD) | (ADDR_W'(1) << BIT_HI_LD) |
    (ADDR_W'(1) << BIT_EXT)   | (ADDR_W'(1) << BIT_WIN)   |
    (ADDR_W'(1) << BIT_RAM_SEL);

  typedef struct packed {
    logic                 win;
    logic [NUM_PTR-1:0]   ld;      // [0]=low pointer, [1]=high pointer
    logic                 rom_sel;
    logic                 ram_sel;
  } dec_t;
endpackage

// File: rtl/alm_window_decode.sv
module alm_window_decode
  import alm_pkg::*;
(
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              romsel_ni,
  input  logic              m2_i,
  output dec_t              dec_o
);
  logic win, ext;
  logic unused_addr;

  assign unused_addr = ^(cpu_addr_i & ~DEC_MASK);

  assign win = romsel_ni & cpu_addr_i[BIT_WIN] & m2_i;
  assign ext = win & cpu_addr_i[BIT_EXT];

  always_comb begin
    dec_o         = '0;
    dec_o.win     = win;
    dec_o.ld[0]   = win & cpu_addr_i[BIT_LO_LD];
    dec_o.ld[1]   = win & cpu_addr_i[BIT_HI_LD];
    dec_o.ram_sel = ext & cpu_addr_i[BIT_RAM_SEL];
    dec_o.rom_sel = ext & ~cpu_addr_i[BIT_RAM_SEL];
  end
endmodule

// File: rtl/alm_ptr_reg.sv
module alm_ptr_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/alm_addr_expand.sv
module alm_addr_expand
  import alm_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CHR_W = 4,
  localparam int RAM_AW = 2*PTR_W,
  localparam int ROM_AW = RAM_AW + 1
) (
  input  logic [PTR_W-1:0]  lo_i,
  input  logic [PTR_W-1:0]  hi_i,
  input  logic              bank16_i,
  input  logic              rw_i,
  input  dec_t              dec_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [CHR_W-1:0]  chr_bank_o,
  output logic              rom_cs_no,
  output logic              ram_cs_no,
  output logic              ram_we_no
);
  logic unused_dec;
  assign unused_dec = ^{dec_i.win, dec_i.ld};

  assign ram_addr_o = {hi_i, lo_i};
  assign rom_addr_o = {bank16_i, hi_i, lo_i};
  assign chr_bank_o = hi_i[PTR_W-1 -: CHR_W];
  assign rom_cs_no  = ~dec_i.rom_sel;
  assign ram_cs_no  = ~dec_i.ram_sel;
  assign ram_we_no  = ~(dec_i.ram_sel & ~rw_i);
endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
  import alm_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CHR_W = 4,
  localparam int RAM_AW = 2*PTR_W,
  localparam int ROM_AW = RAM_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              romsel_ni,
  input  logic              m2_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [PTR_W-1:0]  data_i,
  output logic [PTR_W-1:0]  lo_ptr_o,
  output logic [PTR_W-1:0]  hi_ptr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [CHR_W-1:0]  chr_bank_o,
  output logic              rom_cs_no,
  output logic              ram_cs_no,
  output logic              ram_we_no
);
  dec_t             dec;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];

  alm_window_decode u_dec (
    .cpu_addr_i (cpu_addr_i),
    .romsel_ni  (romsel_ni),
    .m2_i       (m2_i),
    .dec_o      (dec)
  );

  // rw_i deliberately not used for capture: reads latch the bus too
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    alm_ptr_reg #(.W(PTR_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (dec.ld[i]),
      .d_i    (data_i),
      .q_o    (ptr_q[i])
    );
  end

  assign lo_ptr_o = ptr_q[0];
  assign hi_ptr_o = ptr_q[1];

  alm_addr_expand #(.PTR_W(PTR_W), .CHR_W(CHR_W)) u_exp (
    .lo_i       (ptr_q[0]),
    .hi_i       (ptr_q[1]),
    .bank16_i   (cpu_addr_i[BIT_BANK16]),
    .rw_i       (rw_i),
    .dec_i      (dec),
    .rom_addr_o (rom_addr_o),
    .ram_addr_o (ram_addr_o),
    .chr_bank_o (chr_bank_o),
    .rom_cs_no  (rom_cs_no),
    .ram_cs_no  (ram_cs_no),
    .ram_we_no  (ram_we_no)
  );
endmodule

// File: rtl/alm_checker.sv
module alm_checker
  import alm_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CHR_W = 4,
  localparam int RAM_AW = 2*PTR_W,
  localparam int ROM_AW = RAM_AW + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              romsel_ni,
  input logic              m2_i,
  input logic              rw_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [PTR_W-1:0]  data_i,
  input logic [PTR_W-1:0]  lo_ptr_o,
  input logic [PTR_W-1:0]  hi_ptr_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic [CHR_W-1:0]  chr_bank_o,
  input logic              rom_cs_no,
  input logic              ram_cs_no,
  input logic              ram_we_no
);
  logic win;
  assign win = romsel_ni & cpu_addr_i[BIT_WIN] & m2_i;

  assert_closed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |=> $stable(lo_ptr_o) && $stable(hi_ptr_o));

  assert_lo_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && cpu_addr_i[BIT_LO_LD]) |=> lo_ptr_o == $past(data_i));

  assert_lo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && !cpu_addr_i[BIT_LO_LD]) |=> $stable(lo_ptr_o));

  assert_hi_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && cpu_addr_i[BIT_HI_LD]) |=> hi_ptr_o == $past(data_i));

  assert_hi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && !cpu_addr_i[BIT_HI_LD]) |=> $stable(hi_ptr_o));

  assert_cs_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rom_cs_no && !ram_cs_no));

  assert_cs_region_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_cs_no || !ram_cs_no) |-> (win && cpu_addr_i[BIT_EXT]));

  assert_addr_agree_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[RAM_AW-1:0] == ram_addr_o);

  assert_chr_tracks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(hi_ptr_o) |-> $stable(chr_bank_o));

  assert_we_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (!ram_cs_no && !rw_i));
endmodule

bind addr_latch_mapper alm_checker #(.PTR_W(PTR_W), .CHR_W(CHR_W)) u_alm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .romsel_ni  (romsel_ni),
  .m2_i       (m2_i),
  .rw_i       (rw_i),
  .cpu_addr_i (cpu_addr_i),
  .data_i     (data_i),
  .lo_ptr_o   (lo_ptr_o),
  .hi_ptr_o   (hi_ptr_o),
  .rom_addr_o (rom_addr_o),
  .ram_addr_o (ram_addr_o),
  .chr_bank_o (chr_bank_o),
  .rom_cs_no  (rom_cs_no),
  .ram_cs_no  (ram_cs_no),
  .ram_we_no  (ram_we_no)
);

// File: tb/addr_latch_mapper_bench.sv
module addr_latch_mapper_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        romsel_ni = 1'b1;
  logic        m2_i = 1'b0;
  logic        rw_i = 1'b1;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  lo_ptr_o, hi_ptr_o;
  logic [16:0] rom_addr_o;
  logic [15:0] ram_addr_o;
  logic [3:0]  chr_bank_o;
  logic        rom_cs_no, ram_cs_no, ram_we_no;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_lo = '0;
  logic [7:0] exp_hi = '0;

  always #4 clk_i = ~clk_i;

  addr_latch_mapper u_addr_latch_mapper (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic rw,
                       input logic rs, input logic m2);
    @(negedge clk_i);
    cpu_addr_i = a; data_i = d; rw_i = rw; romsel_ni = rs; m2_i = m2;
    #1;
  endtask

  // finish the cycle: capture edge, then idle bus and sample registered results
  task automatic finish_cycle();
    @(posedge clk_i);
    @(negedge clk_i);
    cpu_addr_i = '0; data_i = '0; rw_i = 1'b1; romsel_ni = 1'b1; m2_i = 1'b0;
    #1;
  endtask

  task automatic check_ptrs(input string tag);
    check({tag, " lo"}, 32'(lo_ptr_o), 32'(exp_lo));
    check({tag, " hi"}, 32'(hi_ptr_o), 32'(exp_hi));
  endtask

  task automatic t_reset();
    check_ptrs("R1 reset");
    check("R1 rom_cs", 32'(rom_cs_no), 32'd1);
    check("R1 ram_cs", 32'(ram_cs_no), 32'd1);
    check("R1 ram_we", 32'(ram_we_no), 32'd1);
  endtask

  task automatic t_low_write();
    drive(16'h1010, 8'h5A, 1'b0, 1'b1, 1'b1);
    finish_cycle();
    exp_lo = 8'h5A;
    check_ptrs("R3 low write");
  endtask

  task automatic t_high_read();
    drive(16'h1020, 8'hC3, 1'b1, 1'b1, 1'b1);
    finish_cycle();
    exp_hi = 8'hC3;
    check_ptrs("R4 R6 high read");
    check("R9 chr bank", 32'(chr_bank_o), 32'hC);
  endtask

  task automatic t_both();
    drive(16'h1030, 8'h77, 1'b1, 1'b1, 1'b1);
    finish_cycle();
    exp_lo = 8'h77; exp_hi = 8'h77;
    check_ptrs("R5 both");
    check("R9 chr bank", 32'(chr_bank_o), 32'h7);
  endtask

  task automatic t_window_closed();
    drive(16'h1030, 8'h11, 1'b0, 1'b0, 1'b1);   // strobe active
    finish_cycle();
    check_ptrs("R2 romsel low");
    drive(16'h1030, 8'h22, 1'b0, 1'b1, 1'b0);   // phase low
    finish_cycle();
    check_ptrs("R2 m2 low");
    drive(16'h0030, 8'h33, 1'b0, 1'b1, 1'b1);   // bit 12 clear
    finish_cycle();
    check_ptrs("R2 a12 low");
  endtask

  task automatic t_ext_rom();
    drive(16'h1803, 8'hFF, 1'b1, 1'b1, 1'b1);
    check("R7 rom_cs", 32'(rom_cs_no), 32'd0);
    check("R7 ram_cs", 32'(ram_cs_no), 32'd1);
    check("R8 rom addr a0=1", 32'(rom_addr_o), {15'd0, 1'b1, exp_hi, exp_lo});
    finish_cycle();
    check_ptrs("R3 R4 no load in rom access");
    drive(16'h1802, 8'hFF, 1'b0, 1'b1, 1'b1);
    check("R8 rom addr a0=0", 32'(rom_addr_o), {15'd0, 1'b0, exp_hi, exp_lo});
    check("R10 no we on rom", 32'(ram_we_no), 32'd1);
    finish_cycle();
  endtask

  task automatic t_ext_ram();
    drive(16'h1804, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R7 ram_cs", 32'(ram_cs_no), 32'd0);
    check("R7 rom_cs", 32'(rom_cs_no), 32'd1);
    check("R10 we on write", 32'(ram_we_no), 32'd0);
    check("R8 ram addr", 32'(ram_addr_o), {16'd0, exp_hi, exp_lo});
    finish_cycle();
    drive(16'h1804, 8'h00, 1'b1, 1'b1, 1'b1);
    check("R10 no we on read", 32'(ram_we_no), 32'd1);
    finish_cycle();
  endtask

  task automatic t_outside();
    drive(16'h1004, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R7 outside rom_cs", 32'(rom_cs_no), 32'd1);
    check("R7 outside ram_cs", 32'(ram_cs_no), 32'd1);
    finish_cycle();
  endtask

  task automatic t_region_load();
    drive(16'h1814, 8'h9E, 1'b1, 1'b1, 1'b1);
    check("R11 ram_cs", 32'(ram_cs_no), 32'd0);
    check("R11 old ptr during access", 32'(ram_addr_o), {16'd0, exp_hi, exp_lo});
    finish_cycle();
    exp_lo = 8'h9E;
    check("R11 R8 new ram addr", 32'(ram_addr_o), {16'd0, exp_hi, exp_lo});
    drive(16'h1821, 8'h4B, 1'b1, 1'b1, 1'b1);
    check("R11 rom_cs", 32'(rom_cs_no), 32'd0);
    finish_cycle();
    exp_hi = 8'h4B;
    check_ptrs("R11 hi via rom access");
    check("R8 rom addr after", 32'(rom_addr_o), {15'd0, 1'b0, exp_hi, exp_lo});
    check("R9 chr bank", 32'(chr_bank_o), 32'h4);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_low_write();
    t_high_read();
    t_both();
    t_window_closed();
    t_ext_rom();
    t_ext_ram();
    t_outside();
    t_region_load();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule